// File: doc/BRIEF.md
# High-Speed Burst Entry Sequencer for a Serial Display Data Lane

This block sets the logical state of one data lane of a MIPI D-PHY transmitter. It moves the lane from the low-power stop state into high-speed transmission and back again. A request input starts each burst. The block then walks the lane through a fixed entry handshake: stop, request, bridge, HS-prepare and HS-zero. The handshake never skips a step. After the handshake it sends a sync byte, then streams payload bytes taken from a valid/ready source. The burst ends with a trail interval and a stop-state exit interval.

All durations are counted in byte-clock cycles and come from two packed timing words. Each field is clamped so that it lasts at least one cycle. The words are sampled when a burst starts. Values that change later are ignored until the lane is back in the idle stop state. The outputs are a registered lane-state code and a registered HS byte; they are meant to feed an analog lane driver and a serializer.

Top module: `lane_sot_seq`

## Requirements
- R1: While reset is held, lane_state reads 0 (stop), hs_byte reads 0x00 and tx_ready is low.
- R2: Without a request the lane stays in stop (code 0). A request sampled in idle shows as request state (code 1) on the second cycle after the sampling edge. Lane codes: 0 stop, 1 request, 2 bridge, 3 HS-prepare, 4 HS-zero, 5 HS-data, 6 HS-trail.
- R3: Codes advance only in the order 0, 1, 2, 3, 4, 5. Stop is never followed directly by any code other than 1.
- R4: The request and bridge states each last LPX cycles, where LPX is bits 15:8 of lp_timing. A value of 0 counts as 1.
- R5: HS-prepare lasts hs_timing bits 23:16 cycles and HS-zero lasts hs_timing bits 15:8 cycles, a value of 0 counting as 1. hs_byte is 0x00 in every state except HS-data and HS-trail.
- R6: The first HS-data cycle carries 0xB8. Payload bytes follow, one per cycle, in the order they were accepted. tx_ready is high only while HS-data bytes are being taken.
- R7: The byte accepted with tx_last ends the payload. HS-trail then lasts hs_timing bits 7:0 cycles (0 counts as 1), and every trail byte equals the inverse of bit 7 of the last byte sent, repeated across all 8 bits.
- R8: tx_valid low while tx_ready is high ends the payload. That cycle is the first HS-trail cycle, and the trail length and trail byte are the same as in R7. If no payload byte was sent, the trail byte is 0x00.
- R9: After HS-trail the lane is in stop for THS_EXIT cycles, where THS_EXIT is bits 7:0 of lp_timing and 0 counts as 1. If the request is held high, the next request state appears after exactly THS_EXIT+1 stop cycles.
- R10: The timing words are sampled on the edge that starts a burst. Changes after that edge have no effect until the lane is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_timing | input | 24 | HS-prepare [23:16], HS-zero [15:8], HS-trail [7:0] |
| lp_timing | input | 16 | LPX [15:8], THS_EXIT [7:0] |
| burst_req | input | 1 | Start a burst when the lane is idle |
| tx_data | input | 8 | Payload byte |
| tx_valid | input | 1 | Payload byte present |
| tx_last | input | 1 | Payload byte is the final one of the burst |
| tx_ready | output | 1 | Payload byte is taken on this edge when valid |
| lane_state | output | 3 | Registered lane-state code |
| hs_byte | output | 8 | Registered HS byte for the serializer |

## Verification
The checker watches the handshake order on every cycle: stop may only lead to request, bridge only follows request, and prepare only follows bridge. It also checks that HS-zero carries 0x00, that the first HS-data byte is the sync byte, that the trail byte stays constant, that the trail returns to stop, and that tx_ready only appears in the HS-data phase. The exact dwell counts taken from the packed fields, the clamp of zero fields to one cycle, the payload order, the two ways a burst can end, and the fact that timing changes during a burst are ignored can only be shown by the bench. It compares every cycle against a trace built from the timing values it programmed.

// File: rtl/lane_sot_pkg.sv
package lane_sot_pkg;

  // Codes presented on lane_state; the order is the handshake order.
  typedef enum logic [2:0] {
    LN_STOP   = 3'd0,
    LN_REQ    = 3'd1,
    LN_BRIDGE = 3'd2,
    LN_PREP   = 3'd3,
    LN_ZERO   = 3'd4,
    LN_DATA   = 3'd5,
    LN_TRAIL  = 3'd6
  } lane_code_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LP01,
    S_LP00,
    S_PREP,
    S_ZERO,
    S_SYNC,
    S_DATA,
    S_TRAIL,
    S_EXIT
  } seq_st_e;

  // Index of each duration field in {hs_timing, lp_timing}.
  localparam int F_EXIT  = 0;
  localparam int F_LPX   = 1;
  localparam int F_TRAIL = 2;
  localparam int F_ZERO  = 3;
  localparam int F_PREP  = 4;
  localparam int NUM_FIELDS = 5;

endpackage

// File: rtl/lane_timing_hold.sv
// Captures the duration fields while the lane is idle and presents each one
// as (cycles - 1), with a zero field treated as a one-cycle duration.
module lane_timing_hold #(
  parameter int FW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [3*FW-1:0] hs_word,
  input  logic [2*FW-1:0] lp_word,
  output logic [FW-1:0]   lpx_now_m1,
  output logic [FW-1:0]   exit_m1,
  output logic [FW-1:0]   lpx_m1,
  output logic [FW-1:0]   trail_m1,
  output logic [FW-1:0]   zero_m1,
  output logic [FW-1:0]   prep_m1
);
  import lane_sot_pkg::*;

  localparam int CAT_W = 5 * FW;

  logic [CAT_W-1:0] cat;
  logic [FW-1:0]    raw_q [NUM_FIELDS];
  logic [FW-1:0]    m1    [NUM_FIELDS];
  logic [FW-1:0]    lpx_live;

  assign cat = {hs_word, lp_word};

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)          raw_q[gi] <= '0;
      else if (capture) raw_q[gi] <= cat[gi*FW +: FW];
    end
    assign m1[gi] = (raw_q[gi] == '0) ? '0 : raw_q[gi] - FW'(1);
  end

  // Bypass for the first dwell, which is loaded on the capture edge itself.
  assign lpx_live   = cat[F_LPX*FW +: FW];
  assign lpx_now_m1 = (lpx_live == '0) ? '0 : lpx_live - FW'(1);

  assign exit_m1  = m1[F_EXIT];
  assign lpx_m1   = m1[F_LPX];
  assign trail_m1 = m1[F_TRAIL];
  assign zero_m1  = m1[F_ZERO];
  assign prep_m1  = m1[F_PREP];

endmodule

// File: rtl/lane_dwell_timer.sv
// Single shared down-counter; a load of N gives N+1 cycles before expiry.
module lane_dwell_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lane_sot_seq.sv
module lane_sot_seq #(
  parameter int           FIELD_W   = 8,
  parameter int           DATA_W    = 8,
  parameter logic [7:0]   SYNC_BYTE = 8'hB8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3*FIELD_W-1:0] hs_timing,
  input  logic [2*FIELD_W-1:0] lp_timing,
  input  logic                 burst_req,
  input  logic [DATA_W-1:0]    tx_data,
  input  logic                 tx_valid,
  input  logic                 tx_last,
  output logic                 tx_ready,
  output logic [2:0]           lane_state,
  output logic [DATA_W-1:0]    hs_byte
);
  import lane_sot_pkg::*;

  localparam logic [DATA_W-1:0] SYNC_W = DATA_W'(SYNC_BYTE);

  seq_st_e            st_q, st_n;
  lane_code_e         ln_q, ln_n;
  logic [DATA_W-1:0]  by_q, by_n;
  logic               last_bit_q, last_bit_n;
  logic               ld;
  logic [FIELD_W-1:0] ld_val;
  logic               expired;
  logic [FIELD_W-1:0] lpx_now_m1, exit_m1, lpx_m1, trail_m1, zero_m1, prep_m1;
  logic [DATA_W-1:0]  trail_byte;

  lane_timing_hold #(.FW(FIELD_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .capture    (st_q == S_IDLE),
    .hs_word    (hs_timing),
    .lp_word    (lp_timing),
    .lpx_now_m1 (lpx_now_m1),
    .exit_m1    (exit_m1),
    .lpx_m1     (lpx_m1),
    .trail_m1   (trail_m1),
    .zero_m1    (zero_m1),
    .prep_m1    (prep_m1)
  );

  lane_dwell_timer #(.W(FIELD_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .expired  (expired)
  );

  assign trail_byte = {DATA_W{~last_bit_q}};

  always_comb begin
    st_n       = st_q;
    ln_n       = LN_STOP;
    by_n       = '0;
    last_bit_n = last_bit_q;
    ld         = 1'b0;
    ld_val     = '0;
    case (st_q)
      S_IDLE: begin
        if (burst_req) begin
          st_n = S_LP01; ld = 1'b1; ld_val = lpx_now_m1;
        end
      end
      S_LP01: begin
        ln_n = LN_REQ;
        if (expired) begin
          st_n = S_LP00; ld = 1'b1; ld_val = lpx_m1;
        end
      end
      S_LP00: begin
        ln_n = LN_BRIDGE;
        if (expired) begin
          st_n = S_PREP; ld = 1'b1; ld_val = prep_m1;
        end
      end
      S_PREP: begin
        ln_n = LN_PREP;
        if (expired) begin
          st_n = S_ZERO; ld = 1'b1; ld_val = zero_m1;
        end
      end
      S_ZERO: begin
        ln_n = LN_ZERO;
        if (expired) st_n = S_SYNC;
      end
      S_SYNC: begin
        ln_n       = LN_DATA;
        by_n       = SYNC_W;
        last_bit_n = SYNC_W[DATA_W-1];
        st_n       = S_DATA;
      end
      S_DATA: begin
        if (tx_valid) begin
          ln_n       = LN_DATA;
          by_n       = tx_data;
          last_bit_n = tx_data[DATA_W-1];
          if (tx_last) begin
            st_n = S_TRAIL; ld = 1'b1; ld_val = trail_m1;
          end
        end else begin
          // Underrun: this cycle already counts as the first trail cycle.
          ln_n = LN_TRAIL;
          by_n = trail_byte;
          ld   = 1'b1;
          if (trail_m1 == '0) begin
            st_n = S_EXIT; ld_val = exit_m1;
          end else begin
            st_n = S_TRAIL; ld_val = trail_m1 - FIELD_W'(1);
          end
        end
      end
      S_TRAIL: begin
        ln_n = LN_TRAIL;
        by_n = trail_byte;
        if (expired) begin
          st_n = S_EXIT; ld = 1'b1; ld_val = exit_m1;
        end
      end
      S_EXIT: begin
        if (expired) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      ln_q       <= LN_STOP;
      by_q       <= '0;
      last_bit_q <= 1'b0;
    end else begin
      st_q       <= st_n;
      ln_q       <= ln_n;
      by_q       <= by_n;
      last_bit_q <= last_bit_n;
    end
  end

  assign tx_ready   = (st_q == S_DATA);
  assign lane_state = ln_q;
  assign hs_byte    = by_q;

endmodule

// File: rtl/lane_sot_chk.sv
module lane_sot_chk #(
  parameter int         DW   = 8,
  parameter logic [7:0] SYNC = 8'hB8
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    lane_state,
  input logic [DW-1:0] hs_byte,
  input logic          tx_ready
);

  // R3
  stop_leaves_to_req_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(lane_state) == 3'd0 && lane_state != 3'd0) |-> lane_state == 3'd1);

  // R3
  bridge_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_state == 3'd2 && $past(lane_state) != 3'd2) |-> $past(lane_state) == 3'd1);

  // R3
  prep_after_bridge_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_state == 3'd3 && $past(lane_state) != 3'd3) |-> $past(lane_state) == 3'd2);

  // R5
  zero_byte_chk: assert property (@(posedge clk) disable iff (rst)
    lane_state == 3'd4 |-> hs_byte == '0);

  // R6
  sync_first_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_state == 3'd5 && $past(lane_state) == 3'd4) |-> hs_byte == DW'(SYNC));

  // R6
  ready_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> lane_state == 3'd5);

  // R7
  trail_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_state == 3'd6 && $past(lane_state) == 3'd6) |-> $stable(hs_byte));

  // R9
  trail_to_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(lane_state) == 3'd6 && lane_state != 3'd6) |-> lane_state == 3'd0);

endmodule

bind lane_sot_seq lane_sot_chk #(.DW(DATA_W), .SYNC(SYNC_BYTE)) u_sot_chk (
  .clk        (clk),
  .rst        (rst),
  .lane_state (lane_state),
  .hs_byte    (hs_byte),
  .tx_ready   (tx_ready)
);

// File: tb/lane_sot_seq_test.sv
module lane_sot_seq_test;
  localparam int FW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3*FW-1:0] hs_timing = '0;
  logic [2*FW-1:0] lp_timing = '0;
  logic            burst_req = 1'b0;
  logic [DW-1:0]   tx_data   = '0;
  logic            tx_valid  = 1'b0;
  logic            tx_last   = 1'b0;
  logic            tx_ready;
  logic [2:0]      lane_state;
  logic [DW-1:0]   hs_byte;

  lane_sot_seq uut (
    .clk        (clk),
    .rst        (rst),
    .hs_timing  (hs_timing),
    .lp_timing  (lp_timing),
    .burst_req  (burst_req),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .tx_ready   (tx_ready),
    .lane_state (lane_state),
    .hs_byte    (hs_byte)
  );

  int checks = 0;
  int errors = 0;
  int    exp_ln[$];
  int    exp_by[$];
  string exp_tag[$];
  int    pay[$];

  function automatic int eff(int f);
    return (f == 0) ? 1 : f;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(int ln, int by, string tag, int reps);
    for (int i = 0; i < reps; i++) begin
      exp_ln.push_back(ln);
      exp_by.push_back(by);
      exp_tag.push_back(tag);
    end
  endtask

  // Builds the expected per-cycle trace from the requirements, then drives one burst.
  task automatic run_burst(int l, int p, int z, int t, int e, int n,
                           bit underrun, bit held, bit scramble);
    string x;
    int lastb;
    int idx;
    x = scramble ? " R10" : "";
    pay.delete();
    for (int i = 0; i < n; i++) pay.push_back(int'($urandom_range(0, 255)));
    exp_ln.delete(); exp_by.delete(); exp_tag.delete();
    push(0, 0, {"R2", x}, 1);
    push(1, 0, {"R4", x}, eff(l));
    push(2, 0, {"R4", x}, eff(l));
    push(3, 0, {"R5", x}, eff(p));
    push(4, 0, {"R5", x}, eff(z));
    push(5, 8'hB8, {"R6", x}, 1);
    lastb = 1;
    for (int i = 0; i < n; i++) begin
      push(5, pay[i], {"R6", x}, 1);
      lastb = (pay[i] >> 7) & 1;
    end
    push(6, lastb ? 0 : 255, underrun ? {"R8", x} : {"R7", x}, eff(t));
    push(0, 0, {"R9", x}, eff(e));
    if (held) begin
      push(0, 0, {"R9", x}, 1);
      push(1, 0, {"R9", x}, 1);
    end else begin
      push(0, 0, {"R2", x}, 3);
    end

    @(negedge clk);
    hs_timing = {8'(p), 8'(z), 8'(t)};
    lp_timing = {8'(l), 8'(e)};
    burst_req = 1'b1;
    @(posedge clk);
    idx = 0;
    for (int k = 0; k < exp_ln.size(); k++) begin
      @(negedge clk);
      chk(lane_state == 3'(exp_ln[k]) && hs_byte == 8'(exp_by[k]), exp_tag[k],
          "lane_state/hs_byte", {21'd0, lane_state, hs_byte}, exp_ln[k] * 256 + exp_by[k]);
      burst_req = held;
      if (scramble) begin
        hs_timing = 24'($urandom);
        lp_timing = 16'($urandom);
      end
      if (tx_ready && idx < n) begin
        tx_valid = 1'b1;
        tx_data  = 8'(pay[idx]);
        tx_last  = (idx == n - 1) && !underrun;
        idx++;
      end else begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
      end
    end
    burst_req = 1'b0;
    tx_valid  = 1'b0;
    tx_last   = 1'b0;
    if (held) repeat (300) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(lane_state == 3'd0, "R1", "lane_state", int'(lane_state), 0);
    chk(hs_byte == 8'h00, "R1", "hs_byte", int'(hs_byte), 0);
    chk(tx_ready == 1'b0, "R1", "tx_ready", int'(tx_ready), 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      // R2 idle without request
      chk(lane_state == 3'd0 && hs_byte == 8'h00 && !tx_ready, "R2", "idle lane",
          {21'd0, lane_state, hs_byte}, 0);
    end

    // Compliant setting: prepare 3, zero 7, trail 6, LPX 2, exit 6.
    run_burst(2, 3, 7, 6, 6, 4, 1'b0, 1'b0, 1'b0);
    // All fields zero: every dwell clamps to one cycle (R4 R5 R7 R9).
    run_burst(0, 0, 0, 0, 0, 1, 1'b0, 1'b0, 1'b0);
    // Underrun before any payload: trail byte 0x00, one-cycle trail (R8).
    run_burst(1, 2, 2, 1, 2, 0, 1'b1, 1'b0, 1'b0);
    // Underrun after three bytes with a longer trail (R8).
    run_burst(3, 1, 4, 4, 3, 3, 1'b1, 1'b0, 1'b0);
    // Request held: back-to-back spacing is exit+1 stop cycles (R9).
    run_burst(2, 3, 7, 2, 6, 2, 1'b0, 1'b1, 1'b0);
    // Timing inputs change during the burst (R10).
    run_burst(4, 2, 5, 3, 5, 5, 1'b0, 1'b0, 1'b1);

    for (int r = 0; r < 24; r++) begin
      int n;
      bit ur;
      n  = int'($urandom_range(0, 8));
      ur = (n == 0) ? 1'b1 : 1'($urandom_range(0, 1));
      run_burst(int'($urandom_range(0, 9)), int'($urandom_range(0, 9)),
                int'($urandom_range(0, 9)), int'($urandom_range(0, 9)),
                int'($urandom_range(0, 9)), n, ur, 1'b0, 1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule